// File: doc/BRIEF.md
# Phase-Correct PWM Generator

This block produces a symmetric, glitch-free pulse-width-modulated output from an up/down timer counter and a compare value. The counter starts at zero and climbs one step per enabled tick until it reaches an end value set by the selected resolution of 8, 9 or 10 bits. It then turns and falls back to zero, and the cycle repeats. Each crossing of the compare value moves the output register to a level chosen by a 2-bit compare mode. The level depends on whether the counter was rising or falling at the match, so the pulse stays centred on the counter's turning point.

The counter advances only when `run` is high and the external prescaler asserts `tick` in the same cycle. A new compare value can be written at any time. It is held in a staging register and reaches the comparator only when the counter arrives at the end value, so a duty change never splits a period. The case where the compare value equals the end value is handled separately, and its behaviour depends on whether the prescaler is bypassed.

Top module: `pwm_phase_gen`

## Requirements
- R1: The end value of the count follows `res_sel`: 00 gives 255, 01 gives 511, 10 and 11 give 1023.
- R2: Each enabled step moves the counter by exactly one. At zero it always steps up. While rising, it turns down once it is at or above the end value. A full period with a step in every cycle is twice the end value (510, 1022 or 2046 steps). `cnt_down` is high when the most recent step was downward.
- R3: In a cycle where `run` and `tick` are not both high, the counter, the direction and the output register all hold.
- R4: Only the low 8, 9 or 10 bits of the compare value, matching the resolution, take part in the match. The upper bits have no effect.
- R5: Mode 2'b10 clears the output when the counter rises onto the compare value and sets it when the counter falls onto it. Mode 2'b11 sets on the rising match and clears on the falling match.
- R6: In modes 2'b00 and 2'b01, `pwm_out` is held low. The output register keeps tracking, so selecting mode 2'b10 or 2'b11 again shows its state at once.
- R7: A value written with `cmp_wr` becomes the active compare value on the step that brings the counter to the end value. A write in that same cycle is kept for the following arrival.
- R8: If the active compare value equals the end value and `bypass` is high, the match at the end value leaves the output unchanged, so no pulse is produced.
- R9: If the active compare value equals the end value and `bypass` is low, the output is driven to the rising-match level on each arrival at the end value, and no falling-match action occurs.
- R10: After reset, the counter is zero and rising, the output is low, and both compare registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler step enable |
| run | input | 1 | Counter enable; low stops the counter |
| bypass | input | 1 | High when the prescaler is bypassed (undivided clock) |
| res_sel | input | 2 | Resolution select: 8, 9 or 10 bits |
| mode | input | 2 | Compare mode |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CMP_W | Compare value to stage |
| pwm_out | output | 1 | PWM output pin |
| cnt | output | CNT_W | Current count |
| cnt_down | output | 1 | Direction of the last step (1 = downward) |

## Verification
Two pairs of events can land on the same clock edge. The first is a compare write and the arrival at the end value that loads the staged value. The bench provokes this by timing a write onto exactly the step that reaches the end value. It then checks that the old staged value drives the next falling and rising matches while the new value waits a full period. The second is the rising and falling matches merging when the compare value equals the end value. The bench drives the output register high, switches the rising-match level, and loads a compare value equal to the end value. It then shows that the output holds when `bypass` is high and falls when `bypass` is low. A long run with a random tick pattern, writes, and mode and resolution changes is compared on every cycle against a behavioural model of the requirements.

// File: rtl/pwm_pc_pkg.sv
package pwm_pc_pkg;

   typedef enum logic [1:0] {
      CM_OFF    = 2'b00,
      CM_RSVD   = 2'b01,
      CM_CLR_UP = 2'b10,
      CM_SET_UP = 2'b11
   } cmp_mode_e;

   // Output level applied on a rising-count match.
   function automatic logic rise_level(input cmp_mode_e m);
      return (m == CM_SET_UP) || (m == CM_RSVD);
   endfunction

   // True when the mode connects the output register to the pin.
   function automatic logic pin_connected(input cmp_mode_e m);
      return (m == CM_CLR_UP) || (m == CM_SET_UP);
   endfunction

   localparam int RES_SLOTS = 4;

endpackage

// File: rtl/pwm_pc_counter.sv
module pwm_pc_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt_q,
   output logic             up_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             up_nxt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic at_floor;
   logic below_top;

   always_comb begin
      at_floor  = (cnt_q == '0);
      below_top = (cnt_q < top);
      // Rising from zero always; otherwise keep rising only below the end value.
      up_nxt    = at_floor | (up_q & below_top);
      cnt_nxt   = up_nxt ? (cnt_q + ONE) : (cnt_q - ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (step) begin
         cnt_q <= cnt_nxt;
         up_q  <= up_nxt;
      end
   end

endmodule

// File: rtl/pwm_pc_cmpbuf.sv
module pwm_pc_cmpbuf #(
   parameter int CMP_W = 16,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             wr,
   input  logic [CMP_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cmp_eff
);
   logic [CMP_W-1:0] stage_q;
   logic [CMP_W-1:0] live_q;
   logic [CMP_W-1:0] live_sel;
   logic [CNT_W-1:0] low_bits;
   logic             arrive_top;

   always_comb begin
      arrive_top = step && (cnt_nxt == top);
      // The step that lands on the end value already compares against the staged value.
      live_sel   = arrive_top ? stage_q : live_q;
   end

   if (CMP_W == CNT_W) begin : g_full
      assign low_bits = live_sel;
   end else begin : g_slice
      assign low_bits = live_sel[CNT_W-1:0];
   end

   assign cmp_eff = low_bits & top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         live_q  <= '0;
      end else begin
         if (wr)         stage_q <= wdata;
         if (arrive_top) live_q  <= stage_q;
      end
   end

endmodule

// File: rtl/pwm_pc_outctl.sv
module pwm_pc_outctl
   import pwm_pc_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             bypass,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic             up_nxt,
   input  logic [CNT_W-1:0] cmp_eff,
   input  logic [CNT_W-1:0] top,
   output logic             pin
);
   cmp_mode_e cm;
   logic      lvl_q;
   logic      lvl_nxt;
   logic      hit;
   logic      cmp_at_top;
   logic      up_lvl;

   always_comb begin
      cm         = cmp_mode_e'(mode);
      up_lvl     = rise_level(cm);
      hit        = step && (cnt_nxt == cmp_eff);
      cmp_at_top = (cmp_eff == top);
      lvl_nxt    = lvl_q;
      if (hit) begin
         if (cmp_at_top) begin
            // Rising and falling matches coincide; only a divided clock acts here.
            if (!bypass) lvl_nxt = up_lvl;
         end else begin
            lvl_nxt = up_nxt ? up_lvl : ~up_lvl;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_nxt;
   end

   assign pin = pin_connected(cm) & lvl_q;

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
   import pwm_pc_pkg::*;
#(
   parameter int MIN_RES = 8,
   parameter int NUM_RES = 3,
   parameter int CMP_W   = 16,
   parameter int CNT_W   = MIN_RES + NUM_RES - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             bypass,
   input  logic [1:0]       res_sel,
   input  logic [1:0]       mode,
   input  logic             cmp_wr,
   input  logic [CMP_W-1:0] cmp_wdata,
   output logic             pwm_out,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_down
);
   localparam int MAX_RES = MIN_RES + NUM_RES - 1;

   if (NUM_RES < 1 || NUM_RES > RES_SLOTS) begin : g_bad_num
      $error("NUM_RES must lie in 1..4");
   end
   if (MIN_RES < 2) begin : g_bad_min
      $error("MIN_RES must be at least 2");
   end
   if (CNT_W != MAX_RES || CNT_W > 30) begin : g_bad_cnt
      $error("CNT_W must equal the widest resolution and stay below 31");
   end
   if (CMP_W < CNT_W) begin : g_bad_cmp
      $error("CMP_W must cover the counter width");
   end

   logic [CNT_W-1:0] top_tab [RES_SLOTS];
   logic [CNT_W-1:0] top_val;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cmp_eff;
   logic             up_q;
   logic             up_nxt;
   logic             step;

   for (genvar g = 0; g < RES_SLOTS; g++) begin : g_top
      if (g < NUM_RES) begin : g_used
         assign top_tab[g] = CNT_W'((1 << (MIN_RES + g)) - 1);
      end else begin : g_spare
         assign top_tab[g] = CNT_W'((1 << MAX_RES) - 1);
      end
   end

   assign top_val = top_tab[res_sel];
   assign step    = run & tick;

   pwm_pc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .top     (top_val),
      .cnt_q   (cnt_q),
      .up_q    (up_q),
      .cnt_nxt (cnt_nxt),
      .up_nxt  (up_nxt)
   );

   pwm_pc_cmpbuf #(.CMP_W(CMP_W), .CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .wr      (cmp_wr),
      .wdata   (cmp_wdata),
      .cnt_nxt (cnt_nxt),
      .top     (top_val),
      .cmp_eff (cmp_eff)
   );

   pwm_pc_outctl #(.CNT_W(CNT_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .bypass  (bypass),
      .mode    (mode),
      .cnt_nxt (cnt_nxt),
      .up_nxt  (up_nxt),
      .cmp_eff (cmp_eff),
      .top     (top_val),
      .pin     (pwm_out)
   );

   assign cnt      = cnt_q;
   assign cnt_down = ~up_q;

endmodule

// File: rtl/pwm_pc_chk.sv
module pwm_pc_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             run,
   input logic [1:0]       mode,
   input logic             pwm_out,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_down,
   input logic [CNT_W-1:0] top_val
);
   // R2
   step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1))));

   // R2
   turn_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !cnt_down && cnt == top_val) |=> cnt_down);

   // R2
   turn_at_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && cnt == '0) |=> !cnt_down);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick) |=> ($stable(cnt) && $stable(cnt_down)));

   // R3
   idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick) |=> (!$stable(mode) || $stable(pwm_out)));

   // R6
   pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |-> !pwm_out);

endmodule

bind pwm_phase_gen pwm_pc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .run      (run),
   .mode     (mode),
   .pwm_out  (pwm_out),
   .cnt      (cnt),
   .cnt_down (cnt_down),
   .top_val  (top_val)
);

// File: tb/pwm_phase_gen_tb.sv
module pwm_phase_gen_tb;
   localparam int CMP_W = 16;
   localparam int CNT_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic             run = 1'b0;
   logic             bypass = 1'b0;
   logic [1:0]       res_sel = 2'b00;
   logic [1:0]       mode = 2'b00;
   logic             cmp_wr = 1'b0;
   logic [CMP_W-1:0] cmp_wdata = '0;
   logic             pwm_out;
   logic [CNT_W-1:0] cnt;
   logic             cnt_down;

   int n_run = 0;
   int n_fail = 0;
   int tk = 0;
   string cur_req = "R2";
   bit done = 0;

   // behavioural reference state
   int m_cnt = 0;
   bit m_up = 1;
   int m_buf = 0;
   int m_act = 0;
   bit m_q = 0;

   always #10 clk = ~clk;

   pwm_phase_gen u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .bypass(bypass),
      .res_sel(res_sel), .mode(mode), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .pwm_out(pwm_out), .cnt(cnt), .cnt_down(cnt_down)
   );

   function automatic int top_of(input logic [1:0] r);
      if (r == 2'b00) return 255;
      if (r == 2'b01) return 511;
      return 1023;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_up = 1; m_buf = 0; m_act = 0; m_q = 0;
      end else begin
         int t, n, c;
         bit up;
         t = top_of(res_sel);
         if (run && tick) begin
            up = (m_cnt == 0) || (m_up && m_cnt < t);
            n  = up ? m_cnt + 1 : m_cnt - 1;
            if (n == t) m_act = m_buf;
            c = m_act & t;
            if (n == c) begin
               if (c == t) begin
                  if (!bypass) m_q = (mode == 2'b11 || mode == 2'b01);
               end else if (up) begin
                  m_q = (mode == 2'b11 || mode == 2'b01);
               end else begin
                  m_q = !(mode == 2'b11 || mode == 2'b01);
               end
            end
            m_cnt = n;
            m_up  = up;
         end
         if (cmp_wr) m_buf = int'(cmp_wdata);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_out;
         exp_out = mode[1] ? m_q : 1'b0;
         n_run++;
         if (int'(cnt) != m_cnt || cnt_down != !m_up || pwm_out != exp_out) begin
            n_fail++;
            $display("FAIL %s model compare: cnt=%0d dn=%0b out=%0b expected cnt=%0d dn=%0b out=%0b",
                     cur_req, cnt, cnt_down, pwm_out, m_cnt, !m_up, exp_out);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at step %0d: actual %0d expected %0d", req, tk, act, exp);
      end
   endtask

   task automatic adv_to(input int k);
      while (tk < k) begin
         @(posedge clk);
         tk++;
      end
      #4;
   endtask

   task automatic do_reset();
      @(posedge clk);
      #4;
      rst_n = 0; run = 0; tick = 0; cmp_wr = 0; cmp_wdata = '0;
      repeat (3) @(posedge clk);
      #4;
      rst_n = 1;
      tk = 0;
   endtask

   task automatic start(input logic [1:0] r, input logic [1:0] md, input logic byp, input int cv);
      do_reset();
      res_sel = r; mode = md; bypass = byp;
      run = 1; tick = 1;
      cmp_wr = 1; cmp_wdata = CMP_W'(cv);
      adv_to(1);
      cmp_wr = 0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      // R10 reset state
      do_reset();
      cur_req = "R10";
      chk("R10 cnt", int'(cnt), 0);
      chk("R10 dn", int'(cnt_down), 0);
      chk("R10 out", int'(pwm_out), 0);

      // R1 R2 end values and period
      cur_req = "R2";
      start(2'b00, 2'b10, 1'b1, 0);
      adv_to(255);  chk("R1 top8", int'(cnt), 255); chk("R2 dn", int'(cnt_down), 0);
      adv_to(256);  chk("R2 turn", int'(cnt), 254); chk("R2 dn", int'(cnt_down), 1);
      adv_to(510);  chk("R2 period8", int'(cnt), 0);
      adv_to(511);  chk("R2 rise", int'(cnt), 1); chk("R2 dn", int'(cnt_down), 0);
      start(2'b01, 2'b10, 1'b1, 0);
      adv_to(511);  chk("R1 top9", int'(cnt), 511);
      adv_to(1022); chk("R2 period9", int'(cnt), 0);
      start(2'b10, 2'b10, 1'b1, 0);
      adv_to(1023); chk("R1 top10", int'(cnt), 1023);
      adv_to(2046); chk("R2 period10", int'(cnt), 0);
      start(2'b11, 2'b10, 1'b1, 0);
      adv_to(1024); chk("R1 sel11", int'(cnt), 1022);

      // R4 upper bits ignored, R5 mode 10
      cur_req = "R4";
      start(2'b00, 2'b10, 1'b1, 'hFF40);
      adv_to(445); chk("R4 before down match", int'(pwm_out), 0);
      adv_to(446); chk("R5 down match sets", int'(pwm_out), 1);
      adv_to(573); chk("R4 still high", int'(pwm_out), 1);
      adv_to(574); chk("R5 up match clears", int'(pwm_out), 0);

      // R7 buffered compare, R5 mode 11, R6 disconnected modes
      cur_req = "R7";
      start(2'b00, 2'b11, 1'b1, 100);
      adv_to(100); chk("R7 not yet live", int'(pwm_out), 0);
      adv_to(609); chk("R5 before up match", int'(pwm_out), 0);
      adv_to(610); chk("R5 up match sets", int'(pwm_out), 1);
      adv_to(700);
      run = 0; mode = 2'b01; #1; chk("R6 mode01 low", int'(pwm_out), 0);
      mode = 2'b00; #1; chk("R6 mode00 low", int'(pwm_out), 0);
      mode = 2'b11; #1; chk("R6 state kept", int'(pwm_out), 1);
      run = 1;
      adv_to(701);
      adv_to(919); chk("R5 before down match", int'(pwm_out), 1);
      adv_to(920); chk("R5 down match clears", int'(pwm_out), 0);

      // R7 write landing on the arrival at the end value
      start(2'b00, 2'b11, 1'b1, 64);
      adv_to(254); cmp_wr = 1; cmp_wdata = 16'd200;
      adv_to(255); cmp_wr = 0;
      adv_to(573); chk("R7 coincident write deferred", int'(pwm_out), 0);
      adv_to(574); chk("R7 old value live", int'(pwm_out), 1);

      // R3 idle
      cur_req = "R3";
      start(2'b00, 2'b10, 1'b1, 64);
      adv_to(300); run = 0;
      adv_to(305); chk("R3 run low cnt", int'(cnt), 210); chk("R3 run low dn", int'(cnt_down), 1);
      run = 1; tick = 0;
      adv_to(310); chk("R3 tick low cnt", int'(cnt), 210);
      tick = 1;
      adv_to(311); chk("R3 resume", int'(cnt), 209);

      // R8 / R9 compare equal to the end value
      for (int b = 1; b >= 0; b--) begin
         cur_req = b ? "R8" : "R9";
         start(2'b00, 2'b11, b[0], 64);
         adv_to(574); chk("R8 R9 setup high", int'(pwm_out), 1);
         adv_to(600); cmp_wr = 1; cmp_wdata = 16'h00FF; mode = 2'b10;
         adv_to(601); cmp_wr = 0;
         adv_to(766);
         chk(b ? "R8 hold at top" : "R9 driven at top", int'(pwm_out), b);
         adv_to(1000);
         chk(b ? "R8 no pulse" : "R9 no down action", int'(pwm_out), b);
         adv_to(1276);
         chk(b ? "R8 next top" : "R9 next top", int'(pwm_out), b);
      end

      // long mixed run against the model
      cur_req = "R5";
      start(2'b00, 2'b10, 1'b0, 30);
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         #4;
         tick   = ($urandom % 3) == 0;
         run    = ($urandom % 50) != 0;
         cmp_wr = ($urandom % 40) == 0;
         cmp_wdata = (($urandom % 4) == 0) ? 16'hFFFF : CMP_W'($urandom);
         if (($urandom % 997) == 0) res_sel = 2'($urandom);
         if (($urandom % 500) == 0) mode = 2'($urandom);
         if (($urandom % 700) == 0) bypass = 1'($urandom);
      end
      @(posedge clk);
      @(negedge clk);
      #2;
      finish_run();
   end

endmodule